// File: doc/BRIEF.md
# Two-Digit Multiplexed Seven-Segment Driver

This block drives a pair of seven-segment digits that share a single set of seven segment lines. A single select output tells the display which digit the segment lines currently belong to: a 1 selects the left digit and a 0 selects the right digit. The block alternates between the two digits fast enough that both appear lit at once to the eye.

Two 4-bit values, one per digit, are taken in and decoded to glyphs for 0 to 9 and A to F. A free-running divider on the 100 MHz system clock produces a one-cycle refresh pulse every `TERM+1` cycles. Each pulse flips the select register. All logic runs in the system clock domain. Select and segments are both registered, so they change together on one clock edge. With the default `TERM` of 49999, the select flips every 0.5 ms. Each digit is therefore refreshed at 1 kHz, well above the 50 Hz minimum.

Top module: `dual_digit_ssd_driver`

## Requirements
- R1: While `rst_n` is sampled low, the next edge sets `sel_o` to 0, drives `seg_o` with the decode of `right_i`, and clears the divider. After `rst_n` is sampled high, the first select change happens on the `TERM+1`-th rising edge.
- R2: After that first change, `sel_o` flips exactly once every `TERM+1` clock cycles, and never between refresh pulses.
- R3: When `sel_o` is 1, `seg_o` shows the glyph of `left_i`. When `sel_o` is 0, it shows the glyph of `right_i`.
- R4: Segment bit 6 is segment A, down to bit 0 for segment G, and a 1 lights a segment. The decimal glyphs are: 0=1111110, 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111, 9=1110011.
- R5: The hex glyphs are: A(10)=1110111, b(11)=0011111, C(12)=1001110, d(13)=0111101, E(14)=1001111, F(15)=1000111.
- R6: A change on the value of the digit being shown appears on `seg_o` after the next rising edge.
- R7: A change on the value of the digit not being shown has no effect on `seg_o`.
- R8: On the edge where `sel_o` flips, `seg_o` already carries the glyph of the newly selected digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| left_i | input | 4 | Value shown on the left digit |
| right_i | input | 4 | Value shown on the right digit |
| seg_o | output | 7 | Segment lines, A in bit 6 through G in bit 0, active high |
| sel_o | output | 1 | Digit select, 1 = left, 0 = right |

## Verification
The hardest cases to reach from the ports are the left-digit glyphs, and the behaviour of each input while its digit is hidden. Both appear only in the short window between two refresh pulses.

The bench shortens the divider with a small `TERM`. It measures the select period directly by counting edges between changes. It then waits for each select change and walks new values into the displayed digit within that window, one per cycle. At the same time it drives unrelated values into the hidden digit, so that R6 and R7 are exercised together.

// File: rtl/ssd_mux_pkg.sv
// Package: shared segment type and the value-to-glyph decode.
// Assumes segment bit 6 = A ... bit 0 = G, active high.
package ssd_mux_pkg;

    localparam int unsigned SEG_W = 7;
    localparam int unsigned VAL_W = 4;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [VAL_W-1:0] val_t;

    // Map a 4-bit value to its lit-segment pattern.
    function automatic seg_t seg_decode(input val_t v);
        seg_t s;
        case (v)
            4'h0: s = 7'b1111110;
            4'h1: s = 7'b0110000;
            4'h2: s = 7'b1101101;
            4'h3: s = 7'b1111001;
            4'h4: s = 7'b0110011;
            4'h5: s = 7'b1011011;
            4'h6: s = 7'b1011111;
            4'h7: s = 7'b1110000;
            4'h8: s = 7'b1111111;
            4'h9: s = 7'b1110011;
            4'hA: s = 7'b1110111;
            4'hB: s = 7'b0011111;
            4'hC: s = 7'b1001110;
            4'hD: s = 7'b0111101;
            4'hE: s = 7'b1001111;
            default: s = 7'b1000111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/refresh_divider.sv
// Module: refresh_divider
// Counts system clocks from 0 to TERM and wraps. It raises a one-cycle
// tick on the terminal count.
// Assumes TERM >= 1 and a synchronous active-low reset.
module refresh_divider #(
    parameter int unsigned TERM = 49999
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          tick_o,
    output logic [$clog2(TERM+1)-1:0]     count_o
);
    localparam int unsigned CNT_W = $clog2(TERM + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM);

    logic [CNT_W-1:0] count_q;

    // Terminal-count detect.
    assign tick_o  = (count_q == LAST);
    assign count_o = count_q;

    // Wrap at the terminal value, otherwise increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick_o) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

endmodule

// File: rtl/digit_scan.sv
// Module: digit_scan
// Holds the digit-select register and flips it on each refresh tick.
// It presents the select value for the coming edge and the value of the
// digit that select chooses.
// Assumes tick is a single-cycle pulse in the same clock domain.
module digit_scan
    import ssd_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  val_t left_i,
    input  val_t right_i,
    output logic sel_next_o,
    output val_t val_next_o,
    output logic sel_o
);
    logic sel_q;

    // Select value that the next edge will load.
    always_comb begin
        if (!rst_n) begin
            sel_next_o = 1'b0;
        end else if (tick_i) begin
            sel_next_o = ~sel_q;
        end else begin
            sel_next_o = sel_q;
        end
    end

    // Pick the digit value that matches the upcoming select.
    always_comb begin
        val_next_o = sel_next_o ? left_i : right_i;
    end

    // Select register.
    always_ff @(posedge clk) begin
        sel_q <= sel_next_o;
    end

    assign sel_o = sel_q;

endmodule

// File: rtl/segment_out_reg.sv
// Module: segment_out_reg
// Decodes the chosen digit value and registers the glyph, so that it
// updates on the same edge as the select register.
// Assumes the value input is already the digit for the next select.
module segment_out_reg
    import ssd_mux_pkg::*;
(
    input  logic clk,
    input  val_t val_i,
    output seg_t seg_o
);
    seg_t seg_q;

    // Register the decoded glyph every cycle.
    always_ff @(posedge clk) begin
        seg_q <= seg_decode(val_i);
    end

    assign seg_o = seg_q;

endmodule

// File: rtl/dual_digit_ssd_driver.sv
// Module: dual_digit_ssd_driver
// Top of the two-digit multiplexed seven-segment driver. It combines the
// refresh divider, the digit scanner and the registered glyph output.
// Assumes a single clock domain and a synchronous active-low reset.
module dual_digit_ssd_driver
    import ssd_mux_pkg::*;
#(
    parameter int unsigned TERM = 49999
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] left_i,
    input  logic [3:0] right_i,
    output logic [6:0] seg_o,
    output logic       sel_o
);
    localparam int unsigned CNT_W = $clog2(TERM + 1);

    logic             tick_w;
    logic [CNT_W-1:0] cnt_w;
    logic             sel_next_w;
    val_t             val_next_w;

    refresh_divider #(.TERM(TERM)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_o  (tick_w),
        .count_o (cnt_w)
    );

    digit_scan u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_w),
        .left_i     (left_i),
        .right_i    (right_i),
        .sel_next_o (sel_next_w),
        .val_next_o (val_next_w),
        .sel_o      (sel_o)
    );

    segment_out_reg u_seg (
        .clk   (clk),
        .val_i (val_next_w),
        .seg_o (seg_o)
    );

endmodule

// File: rtl/ssd_driver_checker.sv
// Module: ssd_driver_checker
// Temporal checks on the driver, bound into every instance of the top.
module ssd_driver_checker
    import ssd_mux_pkg::*;
#(
    parameter int unsigned TERM = 49999
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [3:0]                left_i,
    input logic [3:0]                right_i,
    input logic [6:0]                seg_o,
    input logic                      sel_o,
    input logic                      tick,
    input logic [$clog2(TERM+1)-1:0] cnt
);
    logic        seen_rst = 1'b0;
    logic [31:0] gap_q;

    // Record that a reset has been observed.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    // Count cycles since the last tick, independently of the divider.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) gap_q <= '0;
        else                gap_q <= gap_q + 1;
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!seen_rst)
        !rst_n |=> (sel_o == 1'b0 && seg_o == seg_decode($past(right_i)))); // R1

    AST_SEG_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        1'b1 |=> seg_o == seg_decode(sel_o ? $past(left_i) : $past(right_i))); // R6

    AST_SEL_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        rst_n |=> ((sel_o != $past(sel_o)) == $past(tick))); // R2

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        tick |-> gap_q == TERM); // R2

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n || !seen_rst)
        cnt <= TERM); // R2

endmodule

bind dual_digit_ssd_driver ssd_driver_checker #(.TERM(TERM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .left_i  (left_i),
    .right_i (right_i),
    .seg_o   (seg_o),
    .sel_o   (sel_o),
    .tick    (tick_w),
    .cnt     (cnt_w)
);

// File: tb/tb_dual_digit_ssd_driver.sv
module tb_dual_digit_ssd_driver;

    localparam int unsigned TERM = 39;

    // Glyph table from R4/R5, indexed by value.
    localparam logic [6:0] GLYPH [16] = '{
        7'b1111110, 7'b0110000, 7'b1101101, 7'b1111001,
        7'b0110011, 7'b1011011, 7'b1011111, 7'b1110000,
        7'b1111111, 7'b1110011, 7'b1110111, 7'b0011111,
        7'b1001110, 7'b0111101, 7'b1001111, 7'b1000111
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] left_i = 4'd0;
    logic [3:0] right_i = 4'd0;
    logic [6:0] seg_o;
    logic       sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_digit_ssd_driver #(.TERM(TERM)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .left_i  (left_i),
        .right_i (right_i),
        .seg_o   (seg_o),
        .sel_o   (sel_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until sel_o equals lvl (limit keeps it bounded).
    task automatic edges_until(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sel_o != lvl && n < 4 * (TERM + 1));
    endtask

    initial begin
        int n;
        // R4/R5/R1: glyph table walked under reset (right digit shown).
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            right_i = 4'(i);
            left_i  = 4'(15 - i);
            @(negedge clk);
            chk(i < 10 ? "R4 glyph" : "R5 glyph", int'(seg_o), int'(GLYPH[i]));
            chk("R1 sel in reset", int'(sel_o), 0);
        end

        // R1: first toggle comes TERM+1 edges after release.
        @(negedge clk);
        right_i = 4'd3;
        left_i  = 4'd8;
        rst_n   = 1'b1;
        edges_until(1'b1, n);
        chk("R1 first toggle", n, TERM + 1);
        chk("R8 left glyph on rise", int'(seg_o), int'(GLYPH[8]));

        // R2: period of select; R8 on fall.
        edges_until(1'b0, n);
        chk("R2 period", n, TERM + 1);
        chk("R8 right glyph on fall", int'(seg_o), int'(GLYPH[3]));

        // R6/R7: right shown, change right and hidden left every cycle.
        for (int i = 0; i < 8; i++) begin
            right_i = 4'(i);
            left_i  = 4'(15 - i);
            @(negedge clk);
            chk("R3 sel right", int'(sel_o), 0);
            chk("R6 R7 right shown", int'(seg_o), int'(GLYPH[i]));
        end

        edges_until(1'b1, n);
        chk("R2 period", n, TERM + 1 - 8);
        // R3/R6/R7: left shown, change left and hidden right.
        for (int i = 8; i < 16; i++) begin
            left_i  = 4'(i);
            right_i = 4'(i - 8);
            @(negedge clk);
            chk("R3 sel left", int'(sel_o), 1);
            chk("R3 R6 R7 left shown", int'(seg_o), int'(GLYPH[i]));
        end

        // R1: reset while left shown returns to right digit.
        right_i = 4'd12;
        rst_n   = 1'b0;
        @(negedge clk);
        chk("R1 reset sel", int'(sel_o), 0);
        chk("R1 reset seg", int'(seg_o), int'(GLYPH[12]));
        @(negedge clk);
        rst_n = 1'b1;
        edges_until(1'b1, n);
        chk("R1 divider cleared", n, TERM + 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule